// File: doc/BRIEF.md
# Pipelined Control Bundle Stager

This block produces the control strobes for a five-stage, single-issue integer pipeline. In the decode stage it translates the 6-bit primary opcode into one control word with three groups: one for execute, one for memory access and one for write-back. That word enters the decode-to-execute register. At each later boundary the group that the stage just finished with is dropped, and the rest moves forward. The memory and write-back groups reach the execute-to-memory register. Only the write-back group reaches the memory-to-write-back register.

Fetch and decode have no optional controls. Their instruction read and program-counter write happen every cycle, so this block does not generate them. All staging registers advance on every clock edge. In the execute stage a small ALU control unit combines the 2-bit operation class with the function field of register-format instructions, which is staged alongside the control word, to form a 4-bit ALU command. A hazard unit elsewhere can raise a bubble request. The request replaces the word entering the execute stage with all zeros, so that slot does nothing.

Top module: `pipe_ctrl_stager`

## Requirements
- R1: Opcode 0x00 (register format) gives regDst=1, aluSrc=0, class 10, regWrite=1 and every other strobe 0. Opcode 0x23 (load) gives aluSrc=1, class 00, memRead=1, memToReg=1, regWrite=1. Opcode 0x2B (store) gives aluSrc=1, class 00, memWrite=1. Opcode 0x04 (branch-equal) gives class 01, branch=1. Every strobe not listed is 0.
- R2: Any other opcode value produces an all-zero control word.
- R3: Of branch, memRead and memWrite, at most one is high in any cycle, and each belongs only to its instruction (branch-equal, load and store in that order).
- R4: memToReg is high only for a load, and regWrite is high only for register-format instructions and loads.
- R5: The execute outputs show the instruction decoded one clock edge earlier, the memory outputs the one decoded two edges earlier, and the write-back outputs the one decoded three edges earlier.
- R6: A group moves unchanged from one stage to the next, so consecutive instructions of different kinds do not disturb each other's strobes.
- R7: The ALU command (exAluCtl) is 0010 (add) for class 00 and 0110 (subtract) for class 01, whatever the function field.
- R8: For class 10 the function field maps as follows: 0x20 to 0010, 0x22 to 0110, 0x24 to 0000, 0x25 to 0001 and 0x2A to 0111. Any other function value gives 1111.
- R9: While bubbleReq is high at a clock edge, the word written into the decode-to-execute register is all zero. That slot then travels through every stage as a no-op, with exAluCtl 0010.
- R10: A synchronous reset (rst high at an edge) clears every staged register. After that edge all strobes are 0 and exAluCtl is 0010.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all staging registers update every rising edge |
| rst | input | 1 | Synchronous active-high reset |
| bubbleReq | input | 1 | Replace the incoming decode word with a no-op |
| opcode | input | 6 | Primary opcode of the instruction in decode |
| funct | input | 6 | Function field of the instruction in decode |
| exRegDst | output | 1 | Execute: write to the rd field instead of rt |
| exAluSrc | output | 1 | Execute: second operand is the sign-extended immediate |
| exAluCtl | output | 4 | Execute: ALU command |
| memBranch | output | 1 | Memory: branch-equal in this stage |
| memRead | output | 1 | Memory: data read |
| memWrite | output | 1 | Memory: data write |
| wbMemToReg | output | 1 | Write-back: select the loaded value over the ALU result |
| wbRegWrite | output | 1 | Write-back: enable the register-file write |

## Verification
The bench sweeps every opcode against every function value. It inserts bubbles at irregular points and forces a reset in the middle of traffic. Each stage's outputs are compared with a three-deep model of the pipeline that the bench builds from the requirements. This catches a design that latches a group one stage early or late, because the strobes would appear in the wrong cycle. It also catches a group that is not carried unchanged, which would mix strobes from neighbouring instructions. A bubble applied to the wrong register would let a load's memRead leak through. A wrong function map or class default would show up as a wrong ALU command on the unlisted function codes or on the opcodes that are not register-format.

// File: rtl/ctrl_stage_pkg.sv
package ctrl_stage_pkg;
  localparam int OP_W   = 6;
  localparam int FN_W   = 6;
  localparam int ALUC_W = 4;

  typedef enum logic [1:0] {
    CLS_ADD   = 2'b00,
    CLS_SUB   = 2'b01,
    CLS_RTYPE = 2'b10
  } aluClass_e;

  localparam logic [OP_W-1:0] OPC_RTYPE = 6'h00;
  localparam logic [OP_W-1:0] OPC_LOAD  = 6'h23;
  localparam logic [OP_W-1:0] OPC_STORE = 6'h2B;
  localparam logic [OP_W-1:0] OPC_BEQ   = 6'h04;

  typedef struct packed {
    logic      regDst;
    logic      aluSrc;
    aluClass_e aluClass;
  } exGrp_t;

  typedef struct packed {
    logic branch;
    logic memRead;
    logic memWrite;
  } memGrp_t;

  typedef struct packed {
    logic memToReg;
    logic regWrite;
  } wbGrp_t;

  typedef struct packed {
    exGrp_t  ex;
    memGrp_t mem;
    wbGrp_t  wb;
  } ctrlWord_t;
endpackage

// File: rtl/main_decoder.sv
module main_decoder
  import ctrl_stage_pkg::*;
#(
  parameter int OPW = OP_W
) (
  input  logic [OPW-1:0] opcode,
  output ctrlWord_t      decWord
);
  always_comb begin
    decWord = '0;
    unique case (opcode)
      OPC_RTYPE: begin
        decWord.ex.regDst   = 1'b1;
        decWord.ex.aluClass = CLS_RTYPE;
        decWord.wb.regWrite = 1'b1;
      end
      OPC_LOAD: begin
        decWord.ex.aluSrc   = 1'b1;
        decWord.mem.memRead = 1'b1;
        decWord.wb.memToReg = 1'b1;
        decWord.wb.regWrite = 1'b1;
      end
      OPC_STORE: begin
        decWord.ex.aluSrc    = 1'b1;
        decWord.mem.memWrite = 1'b1;
      end
      OPC_BEQ: begin
        decWord.ex.aluClass = CLS_SUB;
        decWord.mem.branch  = 1'b1;
      end
      default: decWord = '0;
    endcase
  end
endmodule

// File: rtl/alu_ctl_unit.sv
module alu_ctl_unit
  import ctrl_stage_pkg::*;
#(
  parameter int FNW = FN_W,
  parameter int ACW = ALUC_W
) (
  input  aluClass_e      aluClass,
  input  logic [FNW-1:0] funct,
  output logic [ACW-1:0] aluCtl
);
  localparam logic [ACW-1:0] CMD_AND = ACW'(4'b0000);
  localparam logic [ACW-1:0] CMD_OR  = ACW'(4'b0001);
  localparam logic [ACW-1:0] CMD_ADD = ACW'(4'b0010);
  localparam logic [ACW-1:0] CMD_SUB = ACW'(4'b0110);
  localparam logic [ACW-1:0] CMD_SLT = ACW'(4'b0111);
  localparam logic [ACW-1:0] CMD_BAD = '1;

  logic [ACW-1:0] rCmd;

  always_comb begin
    unique case (funct)
      FNW'(6'h20): rCmd = CMD_ADD;
      FNW'(6'h22): rCmd = CMD_SUB;
      FNW'(6'h24): rCmd = CMD_AND;
      FNW'(6'h25): rCmd = CMD_OR;
      FNW'(6'h2A): rCmd = CMD_SLT;
      default:     rCmd = CMD_BAD;
    endcase
  end

  always_comb begin
    unique case (aluClass)
      CLS_SUB:   aluCtl = CMD_SUB;
      CLS_RTYPE: aluCtl = rCmd;
      default:   aluCtl = CMD_ADD;
    endcase
  end
endmodule

// File: rtl/ctrl_pipe_regs.sv
module ctrl_pipe_regs
  import ctrl_stage_pkg::*;
#(
  parameter int FNW = FN_W
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           bubbleReq,
  input  ctrlWord_t      decWord,
  input  logic [FNW-1:0] decFunct,
  output exGrp_t         exGrp,
  output logic [FNW-1:0] exFunct,
  output memGrp_t        memGrp,
  output wbGrp_t         wbGrp
);
  ctrlWord_t      idExQ;
  logic [FNW-1:0] idExFunctQ;
  memGrp_t        exMemMemQ;
  wbGrp_t         exMemWbQ;
  wbGrp_t         memWbWbQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      idExQ      <= '0;
      idExFunctQ <= '0;
      exMemMemQ  <= '0;
      exMemWbQ   <= '0;
      memWbWbQ   <= '0;
    end else begin
      idExQ      <= bubbleReq ? '0 : decWord;
      idExFunctQ <= decFunct;
      exMemMemQ  <= idExQ.mem;
      exMemWbQ   <= idExQ.wb;
      memWbWbQ   <= exMemWbQ;
    end
  end

  assign exGrp   = idExQ.ex;
  assign exFunct = idExFunctQ;
  assign memGrp  = exMemMemQ;
  assign wbGrp   = memWbWbQ;

  p_reset_clear_r10: assert property (@(posedge clk)
    rst |=> (idExQ == '0 && exMemMemQ == '0 && exMemWbQ == '0 && memWbWbQ == '0));

  p_bubble_noop_r9: assert property (@(posedge clk) disable iff (rst)
    bubbleReq |=> (idExQ == '0));

  p_mem_onehot_r3: assert property (@(posedge clk) disable iff (rst)
    $onehot0({memGrp.branch, memGrp.memRead, memGrp.memWrite}));

  p_load_uses_imm_r1: assert property (@(posedge clk) disable iff (rst)
    idExQ.mem.memRead |-> idExQ.ex.aluSrc);

  p_wb_m2r_needs_write_r4: assert property (@(posedge clk) disable iff (rst)
    wbGrp.memToReg |-> wbGrp.regWrite);

  p_load_reaches_wb_r6: assert property (@(posedge clk) disable iff (rst)
    memGrp.memRead |=> (wbGrp.memToReg && wbGrp.regWrite));
endmodule

// File: rtl/pipe_ctrl_stager.sv
module pipe_ctrl_stager
  import ctrl_stage_pkg::*;
#(
  parameter int OPW = OP_W,
  parameter int FNW = FN_W,
  parameter int ACW = ALUC_W
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           bubbleReq,
  input  logic [OPW-1:0] opcode,
  input  logic [FNW-1:0] funct,
  output logic           exRegDst,
  output logic           exAluSrc,
  output logic [ACW-1:0] exAluCtl,
  output logic           memBranch,
  output logic           memRead,
  output logic           memWrite,
  output logic           wbMemToReg,
  output logic           wbRegWrite
);
  ctrlWord_t      decWord;
  exGrp_t         exGrp;
  logic [FNW-1:0] exFunct;
  memGrp_t        memGrp;
  wbGrp_t         wbGrp;

  main_decoder #(.OPW(OPW)) u_dec (
    .opcode (opcode),
    .decWord(decWord)
  );

  ctrl_pipe_regs #(.FNW(FNW)) u_regs (
    .clk      (clk),
    .rst      (rst),
    .bubbleReq(bubbleReq),
    .decWord  (decWord),
    .decFunct (funct),
    .exGrp    (exGrp),
    .exFunct  (exFunct),
    .memGrp   (memGrp),
    .wbGrp    (wbGrp)
  );

  alu_ctl_unit #(.FNW(FNW), .ACW(ACW)) u_aluctl (
    .aluClass(exGrp.aluClass),
    .funct   (exFunct),
    .aluCtl  (exAluCtl)
  );

  assign exRegDst   = exGrp.regDst;
  assign exAluSrc   = exGrp.aluSrc;
  assign memBranch  = memGrp.branch;
  assign memRead    = memGrp.memRead;
  assign memWrite   = memGrp.memWrite;
  assign wbMemToReg = wbGrp.memToReg;
  assign wbRegWrite = wbGrp.regWrite;

  p_branch_sub_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(memBranch) |-> $past(exAluCtl) == 4'b0110);
endmodule

// File: tb/tb_pipe_ctrl_stager.sv
module tb_pipe_ctrl_stager;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bubbleReq = 1'b0;
  logic [5:0] opcode = '0;
  logic [5:0] funct = '0;
  logic exRegDst, exAluSrc, memBranch, memRead, memWrite, wbMemToReg, wbRegWrite;
  logic [3:0] exAluCtl;

  int nChecks = 0;
  int nFails = 0;

  localparam logic [10:0] RST_WORD = 11'b0_0_0010_000_00;
  logic [10:0] eE = RST_WORD;
  logic [10:0] eM = RST_WORD;
  logic [10:0] eW = RST_WORD;

  always #10 clk = ~clk;

  pipe_ctrl_stager dut (
    .clk(clk), .rst(rst), .bubbleReq(bubbleReq), .opcode(opcode), .funct(funct),
    .exRegDst(exRegDst), .exAluSrc(exAluSrc), .exAluCtl(exAluCtl),
    .memBranch(memBranch), .memRead(memRead), .memWrite(memWrite),
    .wbMemToReg(wbMemToReg), .wbRegWrite(wbRegWrite)
  );

  // bit layout: [10]regDst [9]aluSrc [8:5]aluCtl [4]branch [3]read [2]write [1]memToReg [0]regWrite
  function automatic logic [10:0] expWord(logic [5:0] op, logic [5:0] fn);
    logic [3:0] ac;
    case (fn)
      6'h20:   ac = 4'b0010;
      6'h22:   ac = 4'b0110;
      6'h24:   ac = 4'b0000;
      6'h25:   ac = 4'b0001;
      6'h2A:   ac = 4'b0111;
      default: ac = 4'b1111;
    endcase
    case (op)
      6'h00:   return {1'b1, 1'b0, ac, 3'b000, 2'b01};
      6'h23:   return {1'b0, 1'b1, 4'b0010, 3'b010, 2'b11};
      6'h2B:   return {1'b0, 1'b1, 4'b0010, 3'b001, 2'b00};
      6'h04:   return {1'b0, 1'b0, 4'b0110, 3'b100, 2'b00};
      default: return RST_WORD;
    endcase
  endfunction

  task automatic check(input string tag, input logic [10:0] got, input logic [10:0] exp);
    nChecks++;
    if (got !== exp) begin
      nFails++;
      $display("FAIL %s: got %b expected %b (t=%0t)", tag, got, exp, $time);
    end
  endtask

  task automatic step(input logic [5:0] op, input logic [5:0] fn, input logic bub, input logic r);
    opcode = op; funct = fn; bubbleReq = bub; rst = r;
    @(posedge clk);
    if (r) begin
      eW = RST_WORD; eM = RST_WORD; eE = RST_WORD;
    end else begin
      eW = eM; eM = eE; eE = bub ? RST_WORD : expWord(op, fn);
    end
    @(negedge clk);
    check("R1 R2 R5 R9 R10 execute strobes", {5'b0, exRegDst, exAluSrc, 4'b0}, {5'b0, eE[10:9], 4'b0});
    check("R7 R8 ALU command", {7'b0, exAluCtl}, {7'b0, eE[8:5]});
    check("R3 R5 R6 memory strobes", {8'b0, memBranch, memRead, memWrite}, {8'b0, eM[4:2]});
    check("R4 R5 R6 write-back strobes", {9'b0, wbMemToReg, wbRegWrite}, {9'b0, eW[1:0]});
  endtask

  initial begin
    #(20 * 150000);
    nChecks++; nFails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    @(negedge clk);
    for (int k = 0; k < 3; k++) step(6'h23, 6'h20, 1'b0, 1'b1); // R10 reset state
    // R5 latency: single load followed by unused opcodes
    step(6'h23, 6'h00, 1'b0, 1'b0);
    for (int k = 0; k < 3; k++) step(6'h3F, 6'h00, 1'b0, 1'b0);
    // R6 dense mix of the four instruction kinds
    for (int k = 0; k < 16; k++) begin
      logic [5:0] ops [4] = '{6'h00, 6'h23, 6'h2B, 6'h04};
      step(ops[k % 4], 6'h20 + 6'(k % 11), 1'b0, 1'b0);
    end
    // full sweep of opcode x function with irregular bubbles (R1 R2 R8 R9)
    for (int i = 0; i < 4096; i++) begin
      step(6'(i >> 6), 6'(i), (i % 13) == 5, 1'b0);
    end
    // R9 bubble over a load, R10 reset in the middle of traffic
    step(6'h23, 6'h00, 1'b1, 1'b0);
    step(6'h23, 6'h00, 1'b0, 1'b0);
    step(6'h2B, 6'h00, 1'b0, 1'b0);
    step(6'h04, 6'h00, 1'b0, 1'b1);
    for (int k = 0; k < 3; k++) step(6'h3F, 6'h2A, 1'b0, 1'b0);
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule